// File: doc/BRIEF.md
# Single-Step Non-Restoring Division Unit

This unit performs one iteration of a non-restoring binary division each time its step strobe is pulsed. Three status bits are held in registers next to the remainder path: a divisor-sign flag M, a partial-remainder sign flag Q and a quotient-bit flag T. On every step the partial remainder on `rem_in` is shifted left by one place, with T entering at the bottom. The divisor is then subtracted or added, depending on whether the stored Q matches M. The unit registers the new remainder and the new Q and T.

Software or a sequencer drives the whole division. It first loads Q, M and T through the flag-load port, then issues one step per quotient bit and feeds `rem_out` back into `rem_in`. A full unsigned 32-bit division takes 32 steps, with the dividend rotated through T between steps. Preparing the initial flags and correcting the sign of the quotient afterwards are left to the caller.

Top module: `divstep_unit`

## Requirements
- R1: After a synchronous active-low reset, `rem_out` is zero and `q_out`, `m_out` and `t_out` are all 0.
- R2: A cycle with `flag_load` high sets `q_out`, `m_out` and `t_out` to `q_set`, `m_set` and `t_set` on the next clock edge, and leaves `rem_out` unchanged.
- R3: A step computes S = {`rem_in` shifted left by one, stored T in bit 0}, modulo 2^W. It registers S minus `divisor` when the stored Q equals the stored M, and S plus `divisor` otherwise, both modulo 2^W.
- R4: On a subtracting step, let X be the bit shifted out of `rem_in` XOR the borrow (borrow = result greater than S). The new Q is X when Q=M=0, and the inverse of X when Q=M=1.
- R5: On an adding step, let Y be the bit shifted out XOR the carry (carry = result less than S). The new Q is the inverse of Y when Q=0, M=1, and Y when Q=1, M=0.
- R6: After a step, T is 1 exactly when the new Q equals M, and M keeps its value.
- R7: When neither `step` nor `flag_load` is high, `rem_out`, `q_out`, `m_out` and `t_out` all hold.
- R8: When `flag_load` and `step` are high in the same cycle, the load takes effect and `rem_out` holds.
- R9: The chain works as a divider for W=32. Set Q=M=T=0 and start with a zero remainder. Then run 32 steps: before each one, rotate the dividend left through T, and feed `rem_out` back into `rem_in`. A final rotate through T then leaves the unsigned quotient in the dividend, for any divisor below 2^31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flag_load | input | 1 | Load Q, M and T from the set inputs |
| q_set | input | 1 | Value loaded into Q |
| m_set | input | 1 | Value loaded into M |
| t_set | input | 1 | Value loaded into T |
| step | input | 1 | Single-cycle strobe that performs one division step |
| divisor | input | W | Divisor operand |
| rem_in | input | W | Partial remainder entering this step |
| rem_out | output | W | Registered partial remainder |
| q_out | output | 1 | Registered Q flag |
| m_out | output | 1 | Registered M flag |
| t_out | output | 1 | Registered T flag |

## Verification
Every result of this unit passes through exactly one register. A load or a step presented in one cycle therefore shows on the outputs after the next rising edge, so the bench drives each strobe for one cycle from a falling edge and compares at the following falling edge. For the hold checks, the bench samples over several idle falling edges. For the chained division, the bench reads T at the falling edge after each step and feeds it into the next dividend rotate, which keeps the 32-step sequence on the same one-cycle-per-step schedule. A 4-bit instance is swept over every remainder, divisor and flag combination, and its expected results are computed arithmetically by the bench.

// File: rtl/divstep_pkg.sv
// Package: shared types for the single-step division unit.
// Assumes: nothing beyond IEEE 1800-2017.
package divstep_pkg;
    // Arithmetic direction chosen for one step.
    typedef enum logic {
        STEP_SUB = 1'b0,
        STEP_ADD = 1'b1
    } step_op_e;

    // Flag triple kept alongside the remainder.
    typedef struct packed {
        logic q;
        logic m;
        logic t;
    } step_flags_t;
endpackage

// File: rtl/divstep_alu.sv
// Module: divstep_alu
// Shifts the partial remainder left with the T bit entering at bit 0, then
// adds or subtracts the divisor. Reports the shifted-out bit and the
// carry/borrow of the W-bit operation.
// Assumes: W >= 2; op is chosen by divstep_flags.
module divstep_alu
    import divstep_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] rem_in,
    input  logic [W-1:0] divisor,
    input  logic         t_in,
    input  step_op_e     op,
    output logic [W-1:0] result,
    output logic         out_bit,
    output logic         cy
);
    localparam int XW = W + 1;

    logic [W-1:0]  shifted;
    logic [XW-1:0] wide;

    // Form the shifted remainder and the extended sum or difference.
    always_comb begin
        shifted = {rem_in[W-2:0], t_in};
        out_bit = rem_in[W-1];
        if (op == STEP_SUB) begin
            wide = {1'b0, shifted} - {1'b0, divisor};
        end else begin
            wide = {1'b0, shifted} + {1'b0, divisor};
        end
        result = wide[W-1:0];
        cy     = wide[XW-1];
    end
endmodule

// File: rtl/divstep_flags.sv
// Module: divstep_flags
// Picks add or subtract from the stored Q and M, and derives the next Q and
// T from the shifted-out bit and the carry/borrow of the ALU.
// Assumes: cy is a carry for STEP_ADD and a borrow for STEP_SUB.
module divstep_flags
    import divstep_pkg::*;
(
    input  logic     old_q,
    input  logic     m,
    input  logic     out_bit,
    input  logic     cy,
    output step_op_e op,
    output logic     new_q,
    output logic     new_t
);
    logic mix;

    // Choose the operation and resolve the next Q for each Q/M pairing.
    always_comb begin
        op  = (old_q == m) ? STEP_SUB : STEP_ADD;
        mix = out_bit ^ cy;
        unique case ({old_q, m})
            2'b00:   new_q = mix;
            2'b11:   new_q = ~mix;
            2'b01:   new_q = ~mix;
            default: new_q = mix;
        endcase
        new_t = (new_q == m);
    end
endmodule

// File: rtl/divstep_unit.sv
// Module: divstep_unit
// One non-restoring division step per strobe. Holds the remainder and the
// Q/M/T flags in registers. A flag load has priority over a step.
// Assumes: step and flag_load are single-cycle pulses; the caller feeds
// rem_out back into rem_in when chaining steps.
module divstep_unit
    import divstep_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flag_load,
    input  logic         q_set,
    input  logic         m_set,
    input  logic         t_set,
    input  logic         step,
    input  logic [W-1:0] divisor,
    input  logic [W-1:0] rem_in,
    output logic [W-1:0] rem_out,
    output logic         q_out,
    output logic         m_out,
    output logic         t_out
);
    step_flags_t  flags_r;
    logic [W-1:0] rem_r;
    step_op_e     op;
    logic [W-1:0] alu_res;
    logic         out_bit;
    logic         cy;
    logic         nq;
    logic         nt;

    divstep_alu #(.W(W)) u_alu (
        .rem_in  (rem_in),
        .divisor (divisor),
        .t_in    (flags_r.t),
        .op      (op),
        .result  (alu_res),
        .out_bit (out_bit),
        .cy      (cy)
    );

    divstep_flags u_flags (
        .old_q   (flags_r.q),
        .m       (flags_r.m),
        .out_bit (out_bit),
        .cy      (cy),
        .op      (op),
        .new_q   (nq),
        .new_t   (nt)
    );

    // Update flags and remainder: reset, then load, then step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_r <= '0;
            rem_r   <= '0;
        end else if (flag_load) begin
            flags_r <= '{q: q_set, m: m_set, t: t_set};
        end else if (step) begin
            flags_r.q <= nq;
            flags_r.t <= nt;
            rem_r     <= alu_res;
        end
    end

    assign rem_out = rem_r;
    assign q_out   = flags_r.q;
    assign m_out   = flags_r.m;
    assign t_out   = flags_r.t;

    // R2: a load shows up on the flag outputs one cycle later.
    a_r2_load_flags: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(flag_load) |->
            (q_out == $past(q_set)) && (m_out == $past(m_set)) && (t_out == $past(t_set)));

    // R6: after a step T reports whether Q matches M, and M is untouched.
    a_r6_t_tracks_q: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(step) && !$past(flag_load) |->
            (t_out == (q_out == m_out)) && $stable(m_out));

    // R7: idle cycles leave every output unchanged.
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(step) && !$past(flag_load) |->
            $stable(rem_out) && $stable(q_out) && $stable(m_out) && $stable(t_out));

    // R8: a load in the same cycle as a step keeps the remainder.
    a_r8_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(flag_load) |-> $stable(rem_out));
endmodule

// File: tb/divstep_unit_tb.sv
// Bench: exhaustive 4-bit sweep plus 32-bit chained divisions.
module divstep_unit_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // 32-bit instance
    logic        ld, qs, ms, ts, st;
    logic [31:0] dv, ri, ro;
    logic        qo, mo, to;
    // 4-bit instance
    logic        ld4, qs4, ms4, ts4, st4;
    logic [3:0]  dv4, ri4, ro4;
    logic        qo4, mo4, to4;

    divstep_unit #(.W(32)) u_dut (
        .clk(clk), .rst_n(rst_n), .flag_load(ld), .q_set(qs), .m_set(ms),
        .t_set(ts), .step(st), .divisor(dv), .rem_in(ri), .rem_out(ro),
        .q_out(qo), .m_out(mo), .t_out(to)
    );

    divstep_unit #(.W(4)) u_dut4 (
        .clk(clk), .rst_n(rst_n), .flag_load(ld4), .q_set(qs4), .m_set(ms4),
        .t_set(ts4), .step(st4), .divisor(dv4), .rem_in(ri4), .rem_out(ro4),
        .q_out(qo4), .m_out(mo4), .t_out(to4)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference step: returns {new_q, remainder} for a w-bit datapath.
    function automatic logic [32:0] ref_step(input int w, input logic [31:0] rem,
        input logic [31:0] div, input logic oq, input logic m, input logic t);
        logic [31:0] mask, sh, res;
        logic        hi, c, q;
        mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
        hi   = rem[w-1];
        sh   = ((rem << 1) | {31'd0, t}) & mask;
        if (oq == m) begin
            res = (sh - div) & mask;
            c   = res > sh;
        end else begin
            res = (sh + div) & mask;
            c   = res < sh;
        end
        if (!oq && !m)     q = hi ^ c;
        else if (oq && m)  q = ~(hi ^ c);
        else if (!oq && m) q = ~(hi ^ c);
        else               q = hi ^ c;
        return {q, res};
    endfunction

    task automatic load4(input logic q, input logic m, input logic t);
        @(negedge clk);
        ld4 = 1'b1; qs4 = q; ms4 = m; ts4 = t;
        @(negedge clk);
        ld4 = 1'b0;
    endtask

    task automatic step4(input logic [3:0] r, input logic [3:0] d);
        @(negedge clk);
        st4 = 1'b1; ri4 = r; dv4 = d;
        @(negedge clk);
        st4 = 1'b0;
    endtask

    task automatic load32(input logic q, input logic m, input logic t);
        @(negedge clk);
        ld = 1'b1; qs = q; ms = m; ts = t;
        @(negedge clk);
        ld = 1'b0;
    endtask

    task automatic step32(input logic [31:0] r, input logic [31:0] d);
        @(negedge clk);
        st = 1'b1; ri = r; dv = d;
        @(negedge clk);
        st = 1'b0;
    endtask

    // R9: full unsigned division by chaining steps with a rotating dividend.
    task automatic divide32(input logic [31:0] a, input logic [31:0] d);
        logic [31:0] dd;
        logic        tb;
        dd = a;
        load32(1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 32; i++) begin
            tb = dd[31];
            dd = {dd[30:0], to};
            load32(qo, mo, tb);
            step32((i == 0) ? 32'd0 : ro, d);
        end
        dd = {dd[30:0], to};
        chk(dd == a / d, "R9 quotient", dd, a / d);
    endtask

    initial begin
        ld = 0; qs = 0; ms = 0; ts = 0; st = 0; dv = '0; ri = '0;
        ld4 = 0; qs4 = 0; ms4 = 0; ts4 = 0; st4 = 0; dv4 = '0; ri4 = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(ro == 32'd0 && {qo, mo, to} == 3'b000, "R1 reset 32", {qo, mo, to}, 32'd0);
        chk(ro4 == 4'd0 && {qo4, mo4, to4} == 3'b000, "R1 reset 4", {qo4, mo4, to4}, 32'd0);

        // Exhaustive sweep on the 4-bit instance.
        for (int f = 0; f < 8; f++) begin
            for (int r = 0; r < 16; r++) begin
                for (int d = 0; d < 16; d++) begin
                    logic [3:0]  prev;
                    logic [32:0] e;
                    logic        fq, fm, ft;
                    fq = f[2]; fm = f[1]; ft = f[0];
                    prev = ro4;
                    load4(fq, fm, ft);
                    chk({qo4, mo4, to4} == {fq, fm, ft}, "R2 flags", {qo4, mo4, to4}, {fq, fm, ft});
                    chk(ro4 == prev, "R2 rem kept", ro4, prev);
                    step4(r[3:0], d[3:0]);
                    e = ref_step(4, {28'd0, r[3:0]}, {28'd0, d[3:0]}, fq, fm, ft);
                    chk(ro4 == e[3:0], "R3 remainder", ro4, e[3:0]);
                    if (fq == fm) chk(qo4 == e[32], "R4 q on subtract", qo4, e[32]);
                    else          chk(qo4 == e[32], "R5 q on add", qo4, e[32]);
                    chk(to4 == (e[32] == fm) && mo4 == fm, "R6 t and m", {mo4, to4}, {fm, e[32] == fm});
                end
            end
        end

        // R3 on the 32-bit instance: wraparound subtract and add.
        load32(1'b0, 1'b0, 1'b1);
        step32(32'h8000_0001, 32'h0000_0010);
        chk(ro == 32'hFFFF_FFF3, "R3 wrap sub", ro, 32'hFFFF_FFF3);
        chk(qo == 1'b0, "R4 q wrap sub", qo, 32'd0);
        load32(1'b1, 1'b0, 1'b0);
        step32(32'hC000_0000, 32'h9000_0000);
        chk(ro == 32'h1000_0000, "R3 wrap add", ro, 32'h1000_0000);
        chk(qo == 1'b0 && to == 1'b1, "R5 q add carry", {qo, to}, 32'd1);

        // R7: idle hold across several cycles.
        begin
            logic [31:0] hr;
            logic [2:0]  hf;
            hr = ro; hf = {qo, mo, to};
            ri = 32'h1234_5678; dv = 32'h1;
            repeat (4) @(negedge clk);
            chk(ro == hr, "R7 rem held", ro, hr);
            chk({qo, mo, to} == hf, "R7 flags held", {qo, mo, to}, hf);
        end

        // R8: load and step together.
        begin
            logic [31:0] hr;
            hr = ro;
            @(negedge clk);
            ld = 1'b1; st = 1'b1; qs = 1'b1; ms = 1'b1; ts = 1'b0;
            ri = 32'hFFFF_0000; dv = 32'h5;
            @(negedge clk);
            ld = 1'b0; st = 1'b0;
            chk(ro == hr, "R8 rem held", ro, hr);
            chk({qo, mo, to} == 3'b110, "R8 flags loaded", {qo, mo, to}, 32'h6);
        end

        divide32(32'd100, 32'd7);
        divide32(32'hDEAD_BEEF, 32'h0000_1234);
        divide32(32'hFFFF_FFFF, 32'd1);
        divide32(32'd5, 32'd9);
        divide32(32'h8000_0000, 32'h7FFF_FFFF);
        divide32(32'h1234_5678, 32'h0001_0000);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule